// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block holds the register state of one bidirectional general-purpose I/O port of parameterised width (eight bits by default). It sits on a simple register bus that carries an address, write and read enables, write data and registered read data. On the pad side it drives, for each bit, an output enable, an output value and a weak pull-up enable, and it takes the raw pin levels back in.

Software sets the direction of each bit and loads the output data latch. The latch can be loaded through either of two addresses. Software reads the stored latch or the live pin levels depending on the address it uses, so a read-modify-write through the latch address never picks up the level of an input pin. A single active-low control bit turns the weak pull-ups on, and the pull-up of any bit set as an output is always forced off. Every access to the pin address produces a one-cycle strobe for a neighbouring change-detection block.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous reset the direction register reads all ones, and the latch reads zero. The pad outputs `pad_oe_o`, `pad_out_o` and `pad_pu_o`, the read data and the strobe are all zero.
- R2: Address 0 is the direction register. A bit of 1 makes that pin an input, with `pad_oe_o` low and `pad_out_o` low. A bit of 0 makes it an output, with `pad_oe_o` high and `pad_out_o` equal to the latch bit.
- R3: A write to address 1 (latch) or to address 2 (pins) loads the write data into the output latch.
- R4: A read of address 1 returns the stored latch value whatever the pin levels are.
- R5: A read of address 2 returns the pin levels through a two-stage synchronizer. A level applied before clock edge j is returned by a read sampled at edge j+2 but not by one sampled at edge j+1.
- R6: Address 3 bit 0 is the pull-up disable bit, and the other bits read as zero. Each `pad_pu_o` bit equals the direction bit AND NOT the disable bit, so a pull-up is never on for an output.
- R7: The pull-up disable bit resets to 1, so no pull-up is on after reset.
- R8: `port_touch_o` is high for exactly the one cycle after each clock edge that samples a read or a write of address 2. It stays low after every other access.
- R9: A read of address 0 returns the direction register. Writing 0xCF makes bits 7:6 and 3:0 inputs and bits 5:4 outputs.
- R10: `bus_rdata_o` is updated only by the edge that samples `bus_re_i` and holds its value otherwise. The pad outputs change one cycle after the register they follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_we_i | input | 1 | Register write enable |
| bus_re_i | input | 1 | Register read enable |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | W | Write data |
| bus_rdata_o | output | W | Registered read data |
| pad_in_i | input | W | Raw pin levels |
| pad_oe_o | output | W | Per-bit output driver enable |
| pad_out_o | output | W | Per-bit driven value |
| pad_pu_o | output | W | Per-bit weak pull-up enable |
| port_touch_o | output | 1 | One-cycle strobe on a pin-address access |

## Verification
A register write takes effect at the edge that samples it. The pad outputs follow one edge later, so the bench checks them at the falling edge after that second rising edge. Read data is due at the falling edge right after the sampling edge. A pin change is checked twice: once by a read one edge too early, which must still return the old level, and once by a read at the first edge that may return the new level. The strobe is checked high at the falling edge after the access and low at the falling edge after that.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR    = 2'd0,
    REG_OUTLAT = 2'd1,
    REG_PINS   = 2'd2,
    REG_CTRL   = 2'd3
  } gp_reg_e;
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) stg[0] <= '0;
    else       stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) stg[s] <= '0;
      else       stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gp_regs.sv
module gp_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      lat_o,
  output logic              pudis_o,
  output logic              touch_o
);
  logic hit_dir, hit_lat, hit_pins, hit_ctrl;

  always_comb begin
    hit_dir  = (addr_i == REG_DIR);
    hit_lat  = (addr_i == REG_OUTLAT);
    hit_pins = (addr_i == REG_PINS);
    hit_ctrl = (addr_i == REG_CTRL);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dir_o   <= '1;
      lat_o   <= '0;
      pudis_o <= 1'b1;
      touch_o <= 1'b0;
    end else begin
      if (we_i && hit_dir)              dir_o   <= wdata_i;
      if (we_i && (hit_lat || hit_pins)) lat_o  <= wdata_i;
      if (we_i && hit_ctrl)             pudis_o <= wdata_i[0];
      touch_o <= (we_i || re_i) && hit_pins;
    end
  end

  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && (addr_i == REG_OUTLAT || addr_i == REG_PINS)) |=> (lat_o == $past(wdata_i))); // R3
  AST_TOUCH_ON_PIN_ACCESS: assert property (@(posedge clk_i) disable iff (rst_i)
    ((we_i || re_i) && addr_i == REG_PINS) |=> touch_o); // R8
  AST_TOUCH_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !((we_i || re_i) && addr_i == REG_PINS) |=> !touch_o); // R8
endmodule

// File: rtl/gp_pad.sv
module gp_pad #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] lat_i,
  input  logic         pudis_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic oe_b, out_b, pu_b;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        oe_b  <= 1'b0;
        out_b <= 1'b0;
        pu_b  <= 1'b0;
      end else begin
        oe_b  <= ~dir_i[i];
        out_b <= lat_i[i] & ~dir_i[i];
        pu_b  <= dir_i[i] & ~pudis_i;
      end
    end
    assign oe_o[i]  = oe_b;
    assign out_o[i] = out_b;
    assign pu_o[i]  = pu_b;
  end
endmodule

// File: rtl/gp_rdmux.sv
module gp_rdmux
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      dir_i,
  input  logic [W-1:0]      lat_i,
  input  logic [W-1:0]      pins_i,
  input  logic              pudis_i,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] sel;

  always_comb begin
    unique case (addr_i)
      REG_DIR:    sel = dir_i;
      REG_OUTLAT: sel = lat_i;
      REG_PINS:   sel = pins_i;
      default:    sel = {{(W-1){1'b0}}, pudis_i};
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)     rdata_o <= '0;
    else if (re_i) rdata_o <= sel;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !re_i |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic [W-1:0]      pad_in_i,
  output logic [W-1:0]      pad_oe_o,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_pu_o,
  output logic              port_touch_o
);
  localparam int SYNC_STAGES = 2;

  logic [W-1:0] dir_q, lat_q, pins_s;
  logic         pudis_q;

  gp_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(pad_in_i), .q_o(pins_s)
  );

  gp_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(bus_we_i), .re_i(bus_re_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .dir_o(dir_q),
    .lat_o(lat_q), .pudis_o(pudis_q), .touch_o(port_touch_o)
  );

  gp_pad #(.W(W)) u_pad (
    .clk_i(clk_i), .rst_i(rst_i), .dir_i(dir_q), .lat_i(lat_q),
    .pudis_i(pudis_q), .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o)
  );

  gp_rdmux #(.W(W)) u_rdmux (
    .clk_i(clk_i), .rst_i(rst_i), .re_i(bus_re_i), .addr_i(bus_addr_i),
    .dir_i(dir_q), .lat_i(lat_q), .pins_i(pins_s), .pudis_i(pudis_q),
    .rdata_o(bus_rdata_o)
  );

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (pad_oe_o == ~$past(dir_q))); // R2
  AST_PU_NEVER_ON_OUTPUT: assert property (@(posedge clk_i) disable iff (rst_i)
    ((pad_oe_o & pad_pu_o) == '0)); // R6
  AST_NO_DRIVE_WHEN_INPUT: assert property (@(posedge clk_i) disable iff (rst_i)
    ((pad_out_o & ~pad_oe_o) == '0)); // R2
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         we, re;
  logic [1:0]   addr;
  logic [W-1:0] wdata, rdata, pin, oe, pout, pu;
  logic         touch;
  int           checks = 0;
  int           fails = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port #(.W(W)) u0 (
    .clk_i(clk), .rst_i(rst), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pin), .pad_oe_o(oe), .pad_out_o(pout), .pad_pu_o(pu),
    .port_touch_o(touch)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    re = 1'b1; addr = a;
    tick();
    re = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    check("R1 oe", oe, '0);
    check("R1 out", pout, '0);
    check("R1 pu", pu, '0);
    check("R1 rdata", rdata, '0);
    check("R1 touch", {7'd0, touch}, '0);
    rd(2'd0, v); check("R1 dir", v, 8'hFF);
    rd(2'd1, v); check("R1 latch", v, 8'h00);
    rd(2'd3, v); check("R7 ctrl", v, 8'h01);
  endtask

  task automatic t_direction();
    logic [W-1:0] v;
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'hCF);
    rd(2'd0, v); check("R9 dir", v, 8'hCF);
    check("R2 oe", oe, 8'h30);
    check("R2 out", pout, 8'h20);
    check("R7 pu", pu, 8'h00);
  endtask

  task automatic t_latch_paths();
    logic [W-1:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h3C);
    tick();
    check("R3 out via pins addr", pout, 8'h3C);
    wr(2'd1, 8'hC3);
    rd(2'd1, v); check("R3 latch via latch addr", v, 8'hC3);
    check("R10 pad lags", pout, 8'hC3);
  endtask

  task automatic t_latch_vs_pins();
    logic [W-1:0] v;
    pin = 8'h5A;
    tick(); tick(); tick();
    rd(2'd1, v); check("R4 latch read", v, 8'hC3);
    rd(2'd2, v); check("R5 pins read", v, 8'h5A);
  endtask

  task automatic t_pin_sync();
    logic [W-1:0] v;
    pin = 8'h96;
    tick();
    rd(2'd2, v); check("R5 early read old", v, 8'h5A);
    rd(2'd2, v); check("R5 read new", v, 8'h96);
  endtask

  task automatic t_pullup();
    logic [W-1:0] v;
    wr(2'd0, 8'hCF);
    wr(2'd3, 8'hFE);
    tick();
    check("R6 pu gated", pu, 8'hCF);
    rd(2'd3, v); check("R6 ctrl read", v, 8'h00);
    wr(2'd0, 8'h0F);
    tick();
    check("R6 pu output off", pu, 8'h0F);
    wr(2'd3, 8'h01);
    tick();
    check("R6 pu disabled", pu, 8'h00);
  endtask

  task automatic t_strobe();
    logic [W-1:0] v;
    rd(2'd2, v);
    check("R8 touch after read", {7'd0, touch}, 8'h01);
    tick();
    check("R8 touch one cycle", {7'd0, touch}, 8'h00);
    wr(2'd2, 8'h11);
    check("R8 touch after write", {7'd0, touch}, 8'h01);
    wr(2'd1, 8'h22);
    check("R8 no touch latch addr", {7'd0, touch}, 8'h00);
    rd(2'd0, v);
    check("R8 no touch dir addr", {7'd0, touch}, 8'h00);
  endtask

  task automatic t_hold();
    logic [W-1:0] v;
    rd(2'd1, v);
    wr(2'd1, 8'h77);
    tick();
    check("R10 rdata hold", rdata, 8'h22);
  endtask

  initial begin
    rst = 1'b1; we = 1'b0; re = 1'b0; addr = '0; wdata = '0; pin = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direction();
    t_latch_paths();
    t_latch_vs_pins();
    t_pin_sync();
    t_pullup();
    t_strobe();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule